// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Register

This block collects the one-cycle event pulses produced by the transmit, receive, management and FIFO logic of an Ethernet MAC. Each event is held in its own fixed bit of a 32-bit event register until software clears it. A companion mask register selects which held events drive a single registered interrupt line. The block also contains a heartbeat supervisor. After each transmission it watches the collision input for a fixed number of cycles, and it raises the heartbeat event when no collision is seen. Software can ask for that check or leave it off.

Software clears events by writing ones through a plain write port. The same port, with the select bit set, writes the mask. A separate one-bit port sets or clears the MAC enable flag. Either FIFO-error event drops that flag on the same clock edge that latches the event, and frame processing stays halted until software writes the flag back to 1.

Top module: `mac_irq_event_reg`

## Requirements
- R1: After a synchronous active-high reset, the event register, the mask register, `irq_o` and `mac_en_o` are all 0.
- R2: Bits are numbered MSB-first, so bit n lives at data index 31-n. The event bits are: 0 heartbeat error, 1 babbling receive, 2 babbling transmit, 3 graceful-stop complete, 4 transmit frame done, 8 management transfer done, 10 late collision, 11 retry limit, 12 transmit underrun, 13 transmit FIFO error, 14 receive FIFO error. These give an implemented mask of 32'hF8BE0000.
- R3: An event pulse sampled high at a clock edge sets its bit at that edge, and the bit stays set until it is cleared.
- R4: A write with `wr_sel_i`=0 clears every event bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: When an event pulse and a clear of the same bit arrive at the same edge, the bit ends up set.
- R6: Reserved bits (5-7, 9, 15-31) of both the event and mask registers always read 0, and writes to them have no effect.
- R7: A write with `wr_sel_i`=1 loads the implemented bits of the mask register from `wr_data_i`.
- R8: `irq_o` is registered. It equals the OR over all bits of (event AND mask) as they stood one edge earlier, so it rises one cycle after the event latches and falls one cycle after the clear or unmask.
- R9: Whenever either FIFO-error event is latched, `mac_en_o` goes to 0 at the same edge. This takes priority over an enable write at that edge.
- R10: With no FIFO error pending, a pulse on `en_wr_i` loads `en_val_i` into `mac_en_o` at the next edge.
- R11: With `hb_chk_en_i` high, a `tx_end_i` pulse sampled at edge T opens a window over edges T+1..T+HB_WINDOW. If `col_i` is low at all of those edges, bit 0 is set at edge T+HB_WINDOW.
- R12: A high `col_i` at any edge inside the window suppresses the heartbeat event. When `hb_chk_en_i` is low, no heartbeat event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| babr_rx_i | input | 1 | Over-length receive frame pulse |
| babt_tx_i | input | 1 | Over-length transmit frame pulse |
| gstop_done_i | input | 1 | Graceful stop complete pulse |
| tx_frame_i | input | 1 | Frame transmitted pulse |
| mgmt_done_i | input | 1 | Management transfer done pulse |
| late_col_i | input | 1 | Late collision pulse |
| retry_lim_i | input | 1 | Collision retry limit pulse |
| tx_underrun_i | input | 1 | Transmit FIFO underrun pulse |
| tx_fifo_err_i | input | 1 | Transmit FIFO error pulse |
| rx_fifo_err_i | input | 1 | Receive FIFO error pulse |
| hb_chk_en_i | input | 1 | Heartbeat check enable |
| tx_end_i | input | 1 | End-of-transmission pulse |
| col_i | input | 1 | Collision input |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = event clear, 1 = mask load |
| wr_data_i | input | 32 | Write data |
| en_wr_i | input | 1 | MAC enable write strobe |
| en_val_i | input | 1 | MAC enable write value |
| evt_o | output | 32 | Event register contents |
| mask_o | output | 32 | Mask register contents |
| irq_o | output | 1 | Combined interrupt |
| mac_en_o | output | 1 | MAC enable flag |

## Verification
The bench builds the block with HB_WINDOW set to 6 rather than the default 32. With the short window, both outcomes of the heartbeat timer can be checked in a few cycles. A collision on the very last edge of the window must suppress the event. With no collision, the event must appear at exactly the sixth edge and not one earlier. The register width stays at its default, so the MSB-first bit positions and the reserved-bit mask are checked as a literal 32-bit layout.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int REG_W = 32;

  // MSB-first bit numbers
  localparam int B_HBERR   = 0;
  localparam int B_BABR    = 1;
  localparam int B_BABT    = 2;
  localparam int B_GSTOP   = 3;
  localparam int B_TXFRM   = 4;
  localparam int B_MGMT    = 8;
  localparam int B_LATECOL = 10;
  localparam int B_RTYLIM  = 11;
  localparam int B_TXUNDER = 12;
  localparam int B_TXFERR  = 13;
  localparam int B_RXFERR  = 14;

  function automatic int idx(input int n);
    return REG_W - 1 - n;
  endfunction

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[idx(B_HBERR)]   = 1'b1;
    m[idx(B_BABR)]    = 1'b1;
    m[idx(B_BABT)]    = 1'b1;
    m[idx(B_GSTOP)]   = 1'b1;
    m[idx(B_TXFRM)]   = 1'b1;
    m[idx(B_MGMT)]    = 1'b1;
    m[idx(B_LATECOL)] = 1'b1;
    m[idx(B_RTYLIM)]  = 1'b1;
    m[idx(B_TXUNDER)] = 1'b1;
    m[idx(B_TXFERR)]  = 1'b1;
    m[idx(B_RXFERR)]  = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] IMPL = impl_mask();
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] ev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) ev_q[i] <= 1'b0;
        else if (set_i[i]) ev_q[i] <= 1'b1;
        else if (clr_en_i && clr_data_i[i]) ev_q[i] <= 1'b0;
      end
    end else begin : g_rsvd
      assign ev_q[i] = 1'b0;
    end
  end

  assign ev_o = ev_q;

  // R3 R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((ev_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((ev_q & $past(clr_data_i & ~set_i)) == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_en_i && set_i == '0) |=> $stable(ev_q));
endmodule

// File: rtl/irq_mask_combiner.sv
module irq_mask_combiner #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] ev_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i) mask_q <= wr_data_i & IMPL;
      irq_q <= |(ev_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_i & mask_q) == '0) |=> !irq_q);

  // R6
  mask_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> ((mask_q & ~IMPL) == '0));
endmodule

// File: rtl/mac_enable_ctrl.sv
module mac_enable_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (halt_i) en_q <= 1'b0;
    else if (wr_en_i) en_q <= wr_val_i;
  end

  assign en_o = en_q;

  // R9
  fifo_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !en_q);

  // R10
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !halt_i) |=> (en_q == $past(wr_val_i)));
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
  parameter int HB_WINDOW = 32,
  localparam int CW = $clog2(HB_WINDOW + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic chk_en_i,
  input  logic tx_end_i,
  input  logic col_i,
  output logic miss_o
);
  logic [CW-1:0] cnt_q;
  logic          active;

  assign active = (cnt_q != '0);
  assign miss_o = chk_en_i && active && !col_i && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (!chk_en_i) cnt_q <= '0;
    else if (tx_end_i) cnt_q <= CW'(HB_WINDOW);
    else if (active) begin
      if (col_i) cnt_q <= '0;
      else cnt_q <= cnt_q - CW'(1);
    end
  end

  // R11
  hb_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_en_i && tx_end_i) |=> (cnt_q == CW'(HB_WINDOW)));

  // R12
  hb_col_chk: assert property (@(posedge clk) disable iff (rst)
    (active && col_i && !tx_end_i) |=> (cnt_q == '0));
endmodule

// File: rtl/mac_irq_event_reg.sv
module mac_irq_event_reg
  import mac_irq_pkg::*;
#(
  parameter int HB_WINDOW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             babr_rx_i,
  input  logic             babt_tx_i,
  input  logic             gstop_done_i,
  input  logic             tx_frame_i,
  input  logic             mgmt_done_i,
  input  logic             late_col_i,
  input  logic             retry_lim_i,
  input  logic             tx_underrun_i,
  input  logic             tx_fifo_err_i,
  input  logic             rx_fifo_err_i,
  input  logic             hb_chk_en_i,
  input  logic             tx_end_i,
  input  logic             col_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  output logic [REG_W-1:0] evt_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o,
  output logic             mac_en_o
);
  logic             hb_miss;
  logic [REG_W-1:0] set_vec;
  logic             fifo_halt;

  hb_supervisor #(.HB_WINDOW(HB_WINDOW)) u_hb (
    .clk(clk), .rst(rst), .chk_en_i(hb_chk_en_i),
    .tx_end_i(tx_end_i), .col_i(col_i), .miss_o(hb_miss)
  );

  always_comb begin
    set_vec = '0;
    set_vec[idx(B_HBERR)]   = hb_miss;
    set_vec[idx(B_BABR)]    = babr_rx_i;
    set_vec[idx(B_BABT)]    = babt_tx_i;
    set_vec[idx(B_GSTOP)]   = gstop_done_i;
    set_vec[idx(B_TXFRM)]   = tx_frame_i;
    set_vec[idx(B_MGMT)]    = mgmt_done_i;
    set_vec[idx(B_LATECOL)] = late_col_i;
    set_vec[idx(B_RTYLIM)]  = retry_lim_i;
    set_vec[idx(B_TXUNDER)] = tx_underrun_i;
    set_vec[idx(B_TXFERR)]  = tx_fifo_err_i;
    set_vec[idx(B_RXFERR)]  = rx_fifo_err_i;
  end

  assign fifo_halt = tx_fifo_err_i | rx_fifo_err_i;

  irq_event_bank #(.W(REG_W), .IMPL(IMPL)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_vec),
    .clr_en_i(wr_en_i && !wr_sel_i), .clr_data_i(wr_data_i), .ev_o(evt_o)
  );

  irq_mask_combiner #(.W(REG_W), .IMPL(IMPL)) u_comb (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i && wr_sel_i),
    .wr_data_i(wr_data_i), .ev_i(evt_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  mac_enable_ctrl u_en (
    .clk(clk), .rst(rst), .halt_i(fifo_halt),
    .wr_en_i(en_wr_i), .wr_val_i(en_val_i), .en_o(mac_en_o)
  );

  // R9
  halt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en_o && !$past(mac_en_o)) |-> !$past(fifo_halt));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(evt_o & mask_o) != '0));

  // R6
  evt_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt_o & ~IMPL) == '0));
endmodule

// File: tb/tb_mac_irq_event_reg.sv
module tb_mac_irq_event_reg;
  localparam int CLK_PERIOD = 10;
  localparam int HBW = 6;
  localparam logic [31:0] IMPL_EXP = 32'hF8BE0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] ev_b = '0;  // babr,babt,gstop,txfrm,mgmt,latecol,rtylim,txunder,txferr,rxferr
  logic hb_en = 1'b0, tx_end = 1'b0, col = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, en_wr = 1'b0, en_val = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] evt_o, mask_o;
  logic irq_o, mac_en_o;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_event_reg #(.HB_WINDOW(HBW)) dut (
    .clk(clk), .rst(rst),
    .babr_rx_i(ev_b[0]), .babt_tx_i(ev_b[1]), .gstop_done_i(ev_b[2]),
    .tx_frame_i(ev_b[3]), .mgmt_done_i(ev_b[4]), .late_col_i(ev_b[5]),
    .retry_lim_i(ev_b[6]), .tx_underrun_i(ev_b[7]), .tx_fifo_err_i(ev_b[8]),
    .rx_fifo_err_i(ev_b[9]), .hb_chk_en_i(hb_en), .tx_end_i(tx_end),
    .col_i(col), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .en_wr_i(en_wr), .en_val_i(en_val), .evt_o(evt_o), .mask_o(mask_o),
    .irq_o(irq_o), .mac_en_o(mac_en_o)
  );

  // reference model
  int bitno[10] = '{1, 2, 3, 4, 8, 10, 11, 12, 13, 14};
  logic [31:0] m_evt = '0, m_mask = '0;
  logic m_irq = 1'b0, m_en = 1'b0;
  int hb_left = 0;

  always @(posedge clk) begin
    logic [31:0] setv;
    logic miss;
    cycles++;
    if (rst) begin
      m_evt = '0; m_mask = '0; m_irq = 0; m_en = 0; hb_left = 0;
    end else begin
      miss = hb_en && hb_left == 1 && !col;
      if (!hb_en) hb_left = 0;
      else if (tx_end) hb_left = HBW;
      else if (hb_left > 0) hb_left = col ? 0 : hb_left - 1;
      setv = '0;
      for (int k = 0; k < 10; k++) if (ev_b[k]) setv[31 - bitno[k]] = 1'b1;
      if (miss) setv[31] = 1'b1;
      m_irq = |(m_evt & m_mask);
      if (wr_en && !wr_sel) m_evt = m_evt & ~wr_data;
      m_evt = (m_evt | setv) & IMPL_EXP;
      if (wr_en && wr_sel) m_mask = wr_data & IMPL_EXP;
      if (ev_b[8] || ev_b[9]) m_en = 0;
      else if (en_wr) m_en = en_val;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({cur_req, " evt"}, evt_o, m_evt);
      check({cur_req, " mask"}, mask_o, m_mask);
      check({cur_req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
      check({cur_req, " en"}, {31'd0, mac_en_o}, {31'd0, m_en});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_ev(input int k);
    tick(); ev_b[k] = 1'b1; tick(); ev_b = '0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    tick(); wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1", evt_o, 32'h0); check("R1", mask_o, 32'h0);
    check("R1", {31'd0, irq_o}, 32'h0); check("R1", {31'd0, mac_en_o}, 32'h0);

    // R2 R3 layout and latch
    cur_req = "R3";
    pulse_ev(0); check("R2", evt_o, 32'h40000000);
    repeat (2) tick(); check("R3", evt_o, 32'h40000000);
    pulse_ev(4); check("R2", evt_o, 32'h40800000);
    pulse_ev(7); check("R2", evt_o, 32'h40880000);

    // R4 write-one-to-clear, zeros leave bits
    cur_req = "R4";
    wr(0, 32'h0); check("R4", evt_o, 32'h40880000);
    wr(0, 32'h00800000); check("R4", evt_o, 32'h40080000);
    // R6 reserved bits ignore writes
    cur_req = "R6";
    wr(0, ~IMPL_EXP); check("R6", evt_o, 32'h40080000);
    wr(0, 32'hFFFFFFFF); check("R4", evt_o, 32'h0);

    // R5 event wins over simultaneous clear
    cur_req = "R5";
    tick(); ev_b[3] = 1; wr_en = 1; wr_sel = 0; wr_data = 32'hFFFFFFFF;
    tick(); ev_b = '0; wr_en = 0; wr_data = '0;
    check("R5", evt_o, 32'h08000000);

    // R7 mask load, R6 reserved mask bits
    cur_req = "R7";
    wr(1, 32'hFFFFFFFF); check("R6", mask_o, IMPL_EXP);
    check("R7", {31'd0, irq_o}, 32'h0);
    tick(); check("R8", {31'd0, irq_o}, 32'h1);
    wr(1, 32'h40000000); check("R7", mask_o, 32'h40000000);
    tick(); check("R8", {31'd0, irq_o}, 32'h0);

    // R8 irq timing: one cycle after latch
    cur_req = "R8";
    pulse_ev(0); check("R8", {31'd0, irq_o}, 32'h0);
    tick(); check("R8", {31'd0, irq_o}, 32'h1);
    wr(0, 32'h40000000); check("R8", {31'd0, irq_o}, 32'h1);
    tick(); check("R8", {31'd0, irq_o}, 32'h0);

    // R10 enable write
    cur_req = "R10";
    tick(); en_wr = 1; en_val = 1; tick(); en_wr = 0;
    check("R10", {31'd0, mac_en_o}, 32'h1);
    // R9 fifo error halts, beats enable write
    cur_req = "R9";
    tick(); ev_b[8] = 1; en_wr = 1; en_val = 1; tick(); ev_b = '0; en_wr = 0;
    check("R9", {31'd0, mac_en_o}, 32'h0); check("R9", evt_o, 32'h08040000);
    tick(); en_wr = 1; tick(); en_wr = 0;
    check("R10", {31'd0, mac_en_o}, 32'h1);
    pulse_ev(9); check("R9", {31'd0, mac_en_o}, 32'h0);
    check("R9", evt_o, 32'h08060000);
    wr(0, 32'hFFFFFFFF);

    // R11 heartbeat expiry exactly at edge T+HBW
    cur_req = "R11";
    hb_en = 1;
    tick(); tx_end = 1; tick(); tx_end = 0;
    repeat (HBW - 1) tick();
    check("R11", evt_o, 32'h0);
    tick(); check("R11", evt_o, 32'h80000000);
    wr(0, 32'h80000000);

    // R12 collision on the last window edge suppresses
    cur_req = "R12";
    tick(); tx_end = 1; tick(); tx_end = 0;
    repeat (HBW - 1) tick();
    col = 1; tick(); col = 0;
    repeat (3) tick(); check("R12", evt_o, 32'h0);
    // R12 check disabled: no event
    hb_en = 0;
    tick(); tx_end = 1; tick(); tx_end = 0;
    repeat (HBW + 3) tick(); check("R12", evt_o, 32'h0);

    // mixed burst
    cur_req = "R3";
    tick(); ev_b = 10'h3FF; tick(); ev_b = '0;
    check("R3", evt_o, 32'h78BE0000);
    wr(0, 32'h70000000); check("R4", evt_o, 32'h08BE0000);
    repeat (3) tick();
    finish_run();
  end
endmodule